// File: doc/BRIEF.md
# Multiplexed LCD Segment Driver

This block turns a small display memory into drive-level selections for the segment and common pins of a passive LCD glass. Software writes sixteen display bytes, a configuration byte and a contrast code through a simple write port. Once the controller is enabled, it steps through the active commons at a rate set by a slow timing tick. For every pin it puts out a two-bit code that selects one of four bias rails: ground, the low intermediate rail, the high intermediate rail or the full LCD supply. The rails themselves and the contrast ladder are outside the block. The contrast code is only held and presented for that external circuit.

Four drive schemes are available: static, 1/2, 1/3 and 1/4 duty. The duty decides how the bits of each display byte map onto segment/common pairs, and with it how many segment pins are in use. During each common phase, the selected segments drive the level opposite to the active common. Unselected segments sit on an inner rail, so they see only a small RMS voltage. Polarity flips after every full pass through the commons, which keeps the average voltage across the glass at zero. The phase clock comes from one of two sources: an external low-speed tick, or the system clock divided down inside the block.

Top module: `lcd_mux_driver`

## Requirements
- R1: After reset the controller is disabled, the contrast code is 0, every display byte is 0, and every segment and common pin carries code 0.
- R2: While the enable bit is 0, every segment and common pin carries code 0 (ground), whatever the display memory holds and whatever ticks arrive.
- R3: Level codes are 0 = ground, 1 = low intermediate rail, 2 = high intermediate rail, 3 = full supply. Pin k's code is at bits [2k+1:2k] of its bus. Static mode uses duty code 0. Bit b of byte n selects segment 8n+b against common 0, and all 128 segments are in use.
- R4: Duty code 1 (1/2). Segment s uses byte s/4. The bit for common c is (s mod 4)*2 + c, so 64 segments are in use.
- R5: Duty code 2 (1/3). Segment s uses byte s/2. Bits 0 to 2 hold commons 0 to 2 for even segments and bits 4 to 6 hold them for odd segments. Bits 3 and 7 are never displayed, and 32 segments are in use.
- R6: Duty code 3 (1/4). Segment s uses byte s/2, bit (s mod 2)*4 + c, so 32 segments are in use.
- R7: When enabled, the active common drives code 3 in a positive frame and code 0 in a negative frame. The other used commons drive code 1 in a positive frame and code 2 in a negative frame. Commons beyond the duty drive 0.
- R8: When enabled in a multiplexed duty, a selected segment drives code 0 (positive frame) or 3 (negative frame), and an unselected one drives 2 (positive) or 1 (negative). In static mode, a selected segment drives the opposite of common 0 and an unselected one drives the same level. Segments beyond the duty's capacity drive 0.
- R9: After enable, the frame starts positive on common 0. Each common lasts PHASE_TICKS ticks and the commons go in ascending order. Polarity flips when the last used common ends.
- R10: Configuration bit 3 picks the tick source. When it is 0, the tick_lo input is used. When it is 1, an internal pulse occurs every HF_DIV system clocks and tick_lo is ignored.
- R11: A write to the contrast address (17) takes effect only while the controller is disabled. Otherwise the code is unchanged.
- R12: The address map is as follows: display bytes at 0 to 15, configuration at 16, contrast at 17. Configuration bit 0 is enable, bits 2:1 are duty and bit 3 is the source select. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_lo | input | 1 | One-cycle pulse from the low-speed timing source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| seg_lvl | output | 256 | Segment level codes, two bits per pin |
| com_lvl | output | 8 | Common level codes, two bits per pin |
| adj_lvl | output | 4 | Contrast code for the external bias ladder |

## Verification
The checks on phase range and on stepping order assume that the duty field changes only while the controller is disabled. A duty change while running could leave the phase counter past the new last common for one step. The bench therefore always writes a configuration with enable cleared before it picks a new duty, and only then enables again. It also assumes that tick_lo is a single-cycle pulse. The bench drives it for exactly one clock per tick, and each tick is followed by at least one idle cycle.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

    localparam int NCOM = 4;

    typedef enum logic [1:0] {
        LV_GND    = 2'd0,
        LV_MID_LO = 2'd1,
        LV_MID_HI = 2'd2,
        LV_TOP    = 2'd3
    } level_e;

    typedef enum logic [1:0] {
        DUTY_STATIC  = 2'd0,
        DUTY_HALF    = 2'd1,
        DUTY_THIRD   = 2'd2,
        DUTY_QUARTER = 2'd3
    } duty_e;

    // packed order places enable at bit 0, duty at 2:1, source at 3
    typedef struct packed {
        logic  clk_sel;
        duty_e duty;
        logic  en;
    } cfg_t;

    function automatic int unsigned segs_per_byte(duty_e d);
        case (d)
            DUTY_STATIC: return 8;
            DUTY_HALF:   return 4;
            default:     return 2;
        endcase
    endfunction

    // flat display-memory bit that holds segment s on common c
    function automatic int unsigned cell_bit(duty_e d, int unsigned s, logic [1:0] c);
        case (d)
            DUTY_STATIC: return s;
            DUTY_HALF:   return (s / 4) * 8 + (s % 4) * 2 + int'(c);
            default:     return (s / 2) * 8 + (s % 2) * 4 + int'(c);
        endcase
    endfunction

endpackage

// File: rtl/lcd_regs.sv
module lcd_regs
    import lcd_pkg::*;
#(
    parameter int MEM_BYTES = 16,
    parameter int ADJ_W     = 4,
    localparam int AW       = $clog2(MEM_BYTES + 2),
    localparam int BW       = $clog2(MEM_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [7:0]             wr_data,
    output logic [MEM_BYTES*8-1:0] mem_flat,
    output cfg_t                   cfg,
    output logic [ADJ_W-1:0]       adj
);
    localparam logic [AW-1:0] A_CFG = AW'(MEM_BYTES);
    localparam logic [AW-1:0] A_ADJ = AW'(MEM_BYTES + 1);

    logic [7:0] mem_q [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= '0;
            cfg <= '0;
            adj <= '0;
        end else if (wr_en) begin
            if (wr_addr < A_CFG) begin
                mem_q[wr_addr[BW-1:0]] <= wr_data;
            end else if (wr_addr == A_CFG) begin
                cfg <= cfg_t'(wr_data[3:0]);
            end else if (wr_addr == A_ADJ && !cfg.en) begin
                adj <= wr_data[ADJ_W-1:0];
            end
        end
    end

    for (genvar n = 0; n < MEM_BYTES; n++) begin : g_flat
        assign mem_flat[n*8 +: 8] = mem_q[n];
    end

endmodule

// File: rtl/lcd_timebase.sv
module lcd_timebase
    import lcd_pkg::*;
#(
    parameter int HF_DIV      = 128,
    parameter int PHASE_TICKS = 4,
    localparam int DW         = $clog2(HF_DIV),
    localparam int TW         = $clog2(PHASE_TICKS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       clk_sel,
    input  duty_e      duty,
    input  logic       tick_lo,
    output logic [1:0] phase,
    output logic       pol
);
    logic [DW-1:0] div_cnt;
    logic [TW-1:0] tk_cnt;
    logic          hf_tick;
    logic          tick;
    logic          phase_end;

    assign hf_tick   = (div_cnt == DW'(HF_DIV - 1));
    assign tick      = clk_sel ? hf_tick : tick_lo;
    assign phase_end = tick && (tk_cnt == TW'(PHASE_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_cnt <= '0;
            tk_cnt  <= '0;
            phase   <= '0;
            pol     <= 1'b0;
        end else begin
            div_cnt <= hf_tick ? '0 : div_cnt + 1'b1;
            if (phase_end) begin
                tk_cnt <= '0;
                if (phase >= duty) begin
                    phase <= '0;
                    pol   <= ~pol;
                end else begin
                    phase <= phase + 2'd1;
                end
            end else if (tick) begin
                tk_cnt <= tk_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lcd_levels.sv
module lcd_levels
    import lcd_pkg::*;
#(
    parameter int MEM_BYTES = 16,
    localparam int NBITS    = MEM_BYTES * 8,
    localparam int NSEG     = MEM_BYTES * 8,
    localparam int IW       = $clog2(NBITS)
) (
    input  logic              en,
    input  duty_e             duty,
    input  logic [1:0]        phase,
    input  logic              pol,
    input  logic [NBITS-1:0]  mem_flat,
    output logic [2*NSEG-1:0] seg_lvl,
    output logic [2*NCOM-1:0] com_lvl
);
    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        level_e      lv;
        int unsigned idx;
        logic        on;
        always_comb begin
            idx = cell_bit(duty, s, phase);
            on  = mem_flat[idx[IW-1:0]];
            lv  = LV_GND;
            if (en && (s < MEM_BYTES * segs_per_byte(duty))) begin
                if (duty == DUTY_STATIC)
                    lv = (on == pol) ? LV_TOP : LV_GND;
                else if (on)
                    lv = pol ? LV_TOP : LV_GND;
                else
                    lv = pol ? LV_MID_LO : LV_MID_HI;
            end
        end
        assign seg_lvl[2*s +: 2] = lv;
    end

    for (genvar c = 0; c < NCOM; c++) begin : g_com
        level_e lv;
        always_comb begin
            if (!en || (c > int'(duty)))
                lv = LV_GND;
            else if (phase == 2'(c))
                lv = pol ? LV_GND : LV_TOP;
            else
                lv = pol ? LV_MID_HI : LV_MID_LO;
        end
        assign com_lvl[2*c +: 2] = lv;
    end

endmodule

// File: rtl/lcd_mux_driver.sv
module lcd_mux_driver
    import lcd_pkg::*;
#(
    parameter int MEM_BYTES   = 16,
    parameter int ADJ_W       = 4,
    parameter int HF_DIV      = 128,
    parameter int PHASE_TICKS = 4,
    localparam int AW         = $clog2(MEM_BYTES + 2),
    localparam int NSEG       = MEM_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_lo,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [7:0]        wr_data,
    output logic [2*NSEG-1:0] seg_lvl,
    output logic [2*NCOM-1:0] com_lvl,
    output logic [ADJ_W-1:0]  adj_lvl
);
    logic [MEM_BYTES*8-1:0] mem_flat;
    cfg_t                   cfg;
    logic                   en_w;
    logic [1:0]             duty_w;
    logic [1:0]             phase;
    logic                   pol;

    assign en_w   = cfg.en;
    assign duty_w = cfg.duty;

    lcd_regs #(.MEM_BYTES(MEM_BYTES), .ADJ_W(ADJ_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mem_flat(mem_flat), .cfg(cfg), .adj(adj_lvl)
    );

    lcd_timebase #(.HF_DIV(HF_DIV), .PHASE_TICKS(PHASE_TICKS)) u_tb (
        .clk(clk), .rst(rst), .en(cfg.en), .clk_sel(cfg.clk_sel),
        .duty(cfg.duty), .tick_lo(tick_lo), .phase(phase), .pol(pol)
    );

    lcd_levels #(.MEM_BYTES(MEM_BYTES)) u_lv (
        .en(cfg.en), .duty(cfg.duty), .phase(phase), .pol(pol),
        .mem_flat(mem_flat), .seg_lvl(seg_lvl), .com_lvl(com_lvl)
    );

endmodule

// File: rtl/lcd_mux_checker.sv
module lcd_mux_checker #(
    parameter int NSEG  = 128,
    parameter int ADJ_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [1:0]        duty,
    input logic [1:0]        phase,
    input logic              pol,
    input logic [ADJ_W-1:0]  adj,
    input logic [2*NSEG-1:0] seg_lvl,
    input logic [7:0]        com_lvl
);
    logic [2:0] outer_n;
    always_comb begin
        outer_n = '0;
        for (int i = 0; i < 4; i++) begin
            if ((i <= int'(duty)) &&
                (com_lvl[2*i +: 2] == 2'd0 || com_lvl[2*i +: 2] == 2'd3))
                outer_n = outer_n + 3'd1;
        end
    end

    AST_OFF_ALL_GND: assert property (@(posedge clk) disable iff (rst)
        !en |-> (seg_lvl == '0 && com_lvl == '0)); // R2

    AST_ADJ_LOCKED: assert property (@(posedge clk) disable iff (rst)
        en |=> $stable(adj)); // R11

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        en |-> (phase <= duty)); // R9

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && phase != $past(phase))
            |-> (phase == $past(phase) + 2'd1 || phase == 2'd0)); // R9

    AST_POL_FLIP_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && $past(phase) != 2'd0 && phase == 2'd0)
            |-> (pol != $past(pol))); // R9

    AST_ONE_OUTER_COM: assert property (@(posedge clk) disable iff (rst)
        (en && duty != 2'd0) |-> (outer_n == 3'd1)); // R7

endmodule

bind lcd_mux_driver lcd_mux_checker #(.NSEG(NSEG), .ADJ_W(ADJ_W)) u_chk (
    .clk(clk), .rst(rst), .en(en_w), .duty(duty_w), .phase(phase),
    .pol(pol), .adj(adj_lvl), .seg_lvl(seg_lvl), .com_lvl(com_lvl)
);

// File: tb/sim_lcd_mux_driver.sv
module sim_lcd_mux_driver;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 16;
    localparam int NSEG = NB * 8;
    localparam int PT   = 4;
    localparam int HFD  = 128;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_lo = 1'b0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [2*NSEG-1:0] seg_lvl;
    logic [7:0]        com_lvl;
    logic [3:0]        adj_lvl;

    int vectors = 0;
    int errors  = 0;

    // bench model of the requirements
    logic [7:0] mmem [NB];
    logic       men = 1'b0, msel = 1'b0, mpol = 1'b0;
    int         mduty = 0, mph = 0, mtk = 0;
    logic [3:0] madj = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_mux_driver u0 (
        .clk(clk), .rst(rst), .tick_lo(tick_lo), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .seg_lvl(seg_lvl),
        .com_lvl(com_lvl), .adj_lvl(adj_lvl)
    );

    function automatic logic [1:0] exp_seg(int s);
        int cap, idx;
        logic on;
        if (!men) return 2'd0;
        cap = (mduty == 0) ? NB*8 : (mduty == 1) ? NB*4 : NB*2;
        if (s >= cap) return 2'd0;
        if (mduty == 0)      idx = s;
        else if (mduty == 1) idx = (s/4)*8 + (s%4)*2 + mph;
        else                 idx = (s/2)*8 + (s%2)*4 + mph;
        on = mmem[idx/8][idx%8];
        if (mduty == 0) return (on == mpol) ? 2'd3 : 2'd0;
        if (on) return mpol ? 2'd3 : 2'd0;
        return mpol ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [1:0] exp_com(int c);
        if (!men || c > mduty) return 2'd0;
        if (c == mph) return mpol ? 2'd0 : 2'd3;
        return mpol ? 2'd2 : 2'd1;
    endfunction

    task automatic check_all(string tag);
        logic [2*NSEG-1:0] es;
        logic [7:0]        ec;
        for (int s = 0; s < NSEG; s++) es[2*s +: 2] = exp_seg(s);
        for (int c = 0; c < 4; c++) ec[2*c +: 2] = exp_com(c);
        vectors++;
        if (seg_lvl !== es || com_lvl !== ec || adj_lvl !== madj) begin
            errors++;
            $display("FAIL %s: got seg=%h com=%h adj=%h exp seg=%h com=%h adj=%h",
                     tag, seg_lvl, com_lvl, adj_lvl, es, ec, madj);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a < NB) mmem[a] = d;
        else if (a == NB) begin
            men = d[0]; mduty = int'(d[2:1]); msel = d[3];
            if (!men) begin mph = 0; mpol = 1'b0; mtk = 0; end
        end else if (a == NB + 1 && !men) madj = d[3:0];
    endtask

    task automatic lo_tick();
        tick_lo = 1'b1;
        @(negedge clk);
        tick_lo = 1'b0;
        @(negedge clk);
        if (men && !msel) begin
            mtk++;
            if (mtk == PT) begin
                mtk = 0;
                if (mph >= mduty) begin mph = 0; mpol = ~mpol; end
                else mph++;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: got run still active, exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1c3d);
        for (int i = 0; i < NB; i++) mmem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset");

        // R2: memory full, controller off, ticks have no effect
        for (int i = 0; i < NB; i++) wr(i, 8'($urandom));
        wr(NB, 8'b0000_0110);
        check_all("R2 disabled");
        repeat (5) lo_tick();
        check_all("R2 disabled after ticks");

        // R11: contrast taken while off, refused while on
        wr(NB + 1, 8'h0B);
        check_all("R11 contrast while off");
        wr(NB, 8'b0000_0001);
        wr(NB + 1, 8'h04);
        check_all("R11 contrast while on");

        // R12: unmapped addresses
        wr(25, 8'hFF);
        wr(31, 8'h00);
        check_all("R12 unmapped write");

        // directed walk for each duty, two full frames, tick by tick
        for (int d = 0; d < 4; d++) begin
            wr(NB, 8'(d << 1));
            for (int i = 0; i < NB; i++) wr(i, 8'($urandom));
            wr(NB, 8'((d << 1) | 1));
            case (d)
                0: check_all("R3 static map");
                1: check_all("R4 half map");
                2: check_all("R5 third map");
                default: check_all("R6 quarter map");
            endcase
            for (int t = 0; t < 2 * (d + 1) * PT; t++) begin
                lo_tick();
                check_all("R9 R7 R8 frame walk");
            end
        end

        // R5: bits 3 and 7 never shown
        wr(NB, 8'b0000_0100);
        for (int i = 0; i < NB; i++) wr(i, 8'h88);
        wr(NB, 8'b0000_0101);
        for (int t = 0; t < 3 * PT; t++) begin
            lo_tick();
            check_all("R5 unused bits");
        end

        // R10: divided system clock source, tick_lo ignored
        wr(NB, 8'b0000_0110);
        wr(NB, 8'b0000_1111);
        repeat (HFD * PT - 1) @(negedge clk);
        vectors++;
        if (com_lvl !== 8'h57) begin
            errors++;
            $display("FAIL R10 before step: got %h exp %h", com_lvl, 8'h57);
        end
        @(negedge clk);
        vectors++;
        if (com_lvl !== 8'h5D) begin
            errors++;
            $display("FAIL R10 at step: got %h exp %h", com_lvl, 8'h5D);
        end
        tick_lo = 1'b1;
        repeat (4) @(negedge clk);
        tick_lo = 1'b0;
        vectors++;
        if (com_lvl !== 8'h5D) begin
            errors++;
            $display("FAIL R10 tick_lo ignored: got %h exp %h", com_lvl, 8'h5D);
        end

        // constrained random
        for (int it = 0; it < 60; it++) begin
            int d;
            d = int'($urandom % 4);
            wr(NB, 8'(d << 1));
            check_all("R2 random off");
            for (int k = 0; k < 6; k++) wr(int'($urandom % NB), 8'($urandom));
            if ($urandom % 4 == 0) wr(NB + 1, 8'($urandom));
            wr(NB, 8'((d << 1) | 1));
            for (int k = 0; k < 5; k++) begin
                int nt;
                nt = int'($urandom % 7);
                for (int t = 0; t < nt; t++) lo_tick();
                if ($urandom % 3 == 0) wr(int'($urandom % NB), 8'($urandom));
                if ($urandom % 5 == 0) wr(NB + 1 + int'($urandom % 2) * 7, 8'($urandom));
                check_all("R3 R4 R5 R6 R7 R8 R9 R11 R12 random");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule